// File: doc/BRIEF.md
# Grouped A/B Output Select and Load Stage

This block is the last register stage of a multi-channel DAC controller. Every channel arrives with two calibrated codes, an A code and a B code. The block keeps one source-select bit per channel, organised as one 8-bit select register per group of eight channels, and copies the chosen code of every channel into that channel's DAC register while the active-low load input is held low. A single global command can force all select bits to 0 or all to 1 in one write.

The same register write port also holds a 3-bit control word and two 14-bit offset DAC codes. One offset code serves group 0 and the other serves all remaining groups. The DAC registers have no read or write path from the host. They reach the analog side only through the channel output bus. That bus is forced to zero while the active-low clear input is low, and the DAC registers keep updating underneath the whole time.

Top module: `dac_out_stage`

## Requirements
- R1: After reset, the control word reads 0, both offset codes read 0x1555, every select bit is 0, every DAC register is 0, and `out_en` is 0.
- R2: A write to address g, with g below the number of groups (0 to 4), loads `wr_data[7:0]` into the select register of group g. Bit i of that register controls channel g*8+i: 0 picks `code_a` and 1 picks `code_b`.
- R3: A write to address 11 sets all select bits to `wr_data[0]` in one cycle.
- R4: On every rising edge where `load_n` is low, each channel's DAC register takes the code named by its select bit. The select bit used is the value held before any register write made on that same edge.
- R5: On every rising edge where `load_n` is high, all DAC registers keep their values.
- R6: A write to address 8 loads `wr_data[2:0]` into the control word, which appears on `ctrl_q`. Bit 2 is the global A/B choice, bit 1 is the temperature-shutdown enable and bit 0 is the soft power-down request.
- R7: A write to address 9 loads `wr_data[13:0]` into the group-0 offset code (`ofs_lo_q`). A write to address 10 loads it into the offset code for the other groups (`ofs_hi_q`).
- R8: `out_en` takes the value of `clear_n` on each rising edge. While `out_en` is 0, `chan_out` is all zero. While `out_en` is 1, `chan_out` shows the DAC registers. DAC registers loaded while clear is low appear as soon as `out_en` returns to 1.
- R9: Writes to addresses 5, 6, 7 and 12 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| code_a | input | 640 | Calibrated A codes, channel c at bits [c*16 +: 16] |
| code_b | input | 640 | Calibrated B codes, same layout |
| load_n | input | 1 | Active-low, level-sensitive load of the DAC registers |
| clear_n | input | 1 | Active-low output clear |
| chan_out | output | 640 | Gated DAC register contents, channel c at bits [c*16 +: 16] |
| out_en | output | 1 | Registered output enable |
| ctrl_q | output | 3 | Control word |
| ofs_lo_q | output | 14 | Offset code for group 0 |
| ofs_hi_q | output | 14 | Offset code for groups 1 to 4 |

## Verification
The assertions assume that reset is held low for at least one clock before any checked cycle, and that all inputs are stable around each rising edge. The bench meets this by changing every input a quarter period after the edge. Random cycles mix loads with writes to every one of the 16 addresses, including the global command and the unused addresses. Some of these random cycles fall on the same edge as a load, which exercises the rule that a load uses the select bits held before the edge. Clear is pulled low at random, so loads made while the output is gated are checked again once it reopens.

// File: rtl/dac_out_stage_pkg.sv
// Package: shared address map and control-word layout for the output stage.
// Assumes at most eight groups, so select addresses 0..7 never collide.
package dac_out_stage_pkg;

    localparam int ADDR_W = 4;
    localparam int CTRL_W = 3;

    // Fixed addresses; group select registers occupy 0..NUM_GROUPS-1.
    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL    = 4'd8,
        ADR_OFS_LO  = 4'd9,
        ADR_OFS_HI  = 4'd10,
        ADR_SEL_ALL = 4'd11
    } reg_addr_e;

    // Control word; bit 2 global A/B, bit 1 thermal enable, bit 0 power-down.
    typedef struct packed {
        logic ab_global;
        logic therm_en;
        logic soft_pd;
    } ctrl_t;

endpackage

// File: rtl/dac_cfg_regs.sv
// Module: configuration register file (per-group select, control, offsets).
// Assumes NUM_GROUPS <= 8, GROUP_SIZE and OFS_W no wider than DATA_W.
module dac_cfg_regs
    import dac_out_stage_pkg::*;
#(
    parameter int NUM_GROUPS = 5,
    parameter int GROUP_SIZE = 8,
    parameter int DATA_W     = 16,
    parameter int OFS_W      = 14,
    parameter logic [OFS_W-1:0] OFS_RST = 14'h1555,
    localparam int NUM_CH    = NUM_GROUPS * GROUP_SIZE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] sel_bits,
    output ctrl_t             ctrl,
    output logic [OFS_W-1:0]  ofs_lo,
    output logic [OFS_W-1:0]  ofs_hi
);

    logic set_all;
    logic unused_data;

    assign set_all     = wr_en && (wr_addr == ADR_SEL_ALL);
    assign unused_data = ^wr_data[DATA_W-1:OFS_W];

    // One select register per group, written directly or by the global command.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sel
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        logic hit;
        assign hit = wr_en && (wr_addr == MY_ADDR);

        // Purpose: hold the A/B source bits of group g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_bits[g*GROUP_SIZE +: GROUP_SIZE] <= '0;
            end else if (set_all) begin
                sel_bits[g*GROUP_SIZE +: GROUP_SIZE] <= {GROUP_SIZE{wr_data[0]}};
            end else if (hit) begin
                sel_bits[g*GROUP_SIZE +: GROUP_SIZE] <= wr_data[GROUP_SIZE-1:0];
            end
        end
    end

    // Purpose: hold the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && (wr_addr == ADR_CTRL)) begin
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // Purpose: hold both offset DAC codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_lo <= OFS_RST;
            ofs_hi <= OFS_RST;
        end else if (wr_en) begin
            if (wr_addr == ADR_OFS_LO) begin
                ofs_lo <= wr_data[OFS_W-1:0];
            end
            if (wr_addr == ADR_OFS_HI) begin
                ofs_hi <= wr_data[OFS_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dac_chan_bank.sv
// Module: one group of DAC registers with its A/B source multiplexers.
// Assumes the select bits and codes are stable at the clock edge.
module dac_chan_bank #(
    parameter int GROUP_SIZE = 8,
    parameter int CODE_W     = 16,
    localparam int BUS_W     = GROUP_SIZE * CODE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_n,
    input  logic [GROUP_SIZE-1:0] sel,
    input  logic [BUS_W-1:0]      code_a,
    input  logic [BUS_W-1:0]      code_b,
    output logic [BUS_W-1:0]      dac_q
);

    for (genvar i = 0; i < GROUP_SIZE; i++) begin : g_ch
        logic [CODE_W-1:0] pick;
        assign pick = sel[i] ? code_b[i*CODE_W +: CODE_W]
                             : code_a[i*CODE_W +: CODE_W];

        // Purpose: DAC register of channel i, follows its source while load is low.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dac_q[i*CODE_W +: CODE_W] <= '0;
            end else if (!load_n) begin
                dac_q[i*CODE_W +: CODE_W] <= pick;
            end
        end
    end

endmodule

// File: rtl/dac_out_gate.sv
// Module: registers the clear input into an output enable and gates the bus.
// Assumes clear_n is already synchronous to clk.
module dac_out_gate #(
    parameter int BUS_W = 640
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_n,
    input  logic [BUS_W-1:0] dac_bits,
    output logic             out_en,
    output logic [BUS_W-1:0] chan_out
);

    // Purpose: sample the clear input into the enable flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en <= 1'b0;
        end else begin
            out_en <= clear_n;
        end
    end

    // Purpose: force the outputs to zero while disabled.
    always_comb begin
        chan_out = out_en ? dac_bits : '0;
    end

endmodule

// File: rtl/dac_out_stage.sv
// Module: top of the final output stage; per-channel A/B selection, level
// load into DAC registers, control and offset registers, clear gating.
// Assumes all inputs synchronous to clk; reset is synchronous, active low.
module dac_out_stage
    import dac_out_stage_pkg::*;
#(
    parameter int NUM_GROUPS = 5,
    parameter int GROUP_SIZE = 8,
    parameter int CODE_W     = 16,
    parameter int DATA_W     = 16,
    parameter int OFS_W      = 14,
    localparam int NUM_CH    = NUM_GROUPS * GROUP_SIZE,
    localparam int BUS_W     = NUM_CH * CODE_W,
    localparam int GBUS_W    = GROUP_SIZE * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BUS_W-1:0]  code_a,
    input  logic [BUS_W-1:0]  code_b,
    input  logic              load_n,
    input  logic              clear_n,
    output logic [BUS_W-1:0]  chan_out,
    output logic              out_en,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [OFS_W-1:0]  ofs_lo_q,
    output logic [OFS_W-1:0]  ofs_hi_q
);

    logic [NUM_CH-1:0] sel_bits;
    logic [BUS_W-1:0]  dac_bits;
    ctrl_t             ctrl;

    assign ctrl_q = ctrl;

    dac_cfg_regs #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_SIZE (GROUP_SIZE),
        .DATA_W     (DATA_W),
        .OFS_W      (OFS_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sel_bits (sel_bits),
        .ctrl     (ctrl),
        .ofs_lo   (ofs_lo_q),
        .ofs_hi   (ofs_hi_q)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        dac_chan_bank #(
            .GROUP_SIZE (GROUP_SIZE),
            .CODE_W     (CODE_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_n (load_n),
            .sel    (sel_bits[g*GROUP_SIZE +: GROUP_SIZE]),
            .code_a (code_a[g*GBUS_W +: GBUS_W]),
            .code_b (code_b[g*GBUS_W +: GBUS_W]),
            .dac_q  (dac_bits[g*GBUS_W +: GBUS_W])
        );
    end

    dac_out_gate #(
        .BUS_W (BUS_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_n  (clear_n),
        .dac_bits (dac_bits),
        .out_en   (out_en),
        .chan_out (chan_out)
    );

endmodule

// File: rtl/dac_out_stage_chk.sv
// Module: property checker for the output stage, bound to the top module.
// Assumes reset is asserted for at least one edge before checking starts.
module dac_out_stage_chk #(
    parameter int NUM_CH = 40,
    parameter int BUS_W  = 640,
    parameter int OFS_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [15:0]       wr_data,
    input logic              load_n,
    input logic              clear_n,
    input logic [NUM_CH-1:0] sel_bits,
    input logic [BUS_W-1:0]  dac_bits,
    input logic [BUS_W-1:0]  chan_out,
    input logic [2:0]        ctrl_q,
    input logic [OFS_W-1:0]  ofs_lo_q
);

    // R5
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(dac_bits));

    // R3
    sel_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd11) |=>
            (sel_bits == ($past(wr_data[0]) ? {NUM_CH{1'b1}} : {NUM_CH{1'b0}})));

    // R8
    clear_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |=> (chan_out == '0));

    // R8
    open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_n |=> (chan_out == dac_bits));

    // R6
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd8) |=> (ctrl_q == $past(wr_data[2:0])));

    // R7
    ofs_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd9) |=> (ofs_lo_q == $past(wr_data[OFS_W-1:0])));

endmodule

bind dac_out_stage dac_out_stage_chk #(
    .NUM_CH (NUM_CH),
    .BUS_W  (BUS_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load_n   (load_n),
    .clear_n  (clear_n),
    .sel_bits (sel_bits),
    .dac_bits (dac_bits),
    .chan_out (chan_out),
    .ctrl_q   (ctrl_q),
    .ofs_lo_q (ofs_lo_q)
);

// File: tb/dac_out_stage_bench.sv
// Bench: directed corners plus seeded random cycles against a bench model.
module dac_out_stage_bench;

    localparam int PERIOD = 10;
    localparam int NG     = 5;
    localparam int GS     = 8;
    localparam int CW     = 16;
    localparam int NCH    = NG * GS;
    localparam int BW     = NCH * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [BW-1:0] code_a = '0;
    logic [BW-1:0] code_b = '0;
    logic          load_n = 1'b1;
    logic          clear_n = 1'b1;
    logic [BW-1:0] chan_out;
    logic          out_en;
    logic [2:0]    ctrl_q;
    logic [13:0]   ofs_lo_q;
    logic [13:0]   ofs_hi_q;

    // bench model state
    logic [NCH-1:0] sel_m;
    logic [BW-1:0]  dac_m;
    logic [2:0]     ctrl_m;
    logic [13:0]    ofs_lo_m;
    logic [13:0]    ofs_hi_m;
    logic           oe_m;

    int n_chk  = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    dac_out_stage u_dac_out_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .code_a   (code_a),
        .code_b   (code_b),
        .load_n   (load_n),
        .clear_n  (clear_n),
        .chan_out (chan_out),
        .out_en   (out_en),
        .ctrl_q   (ctrl_q),
        .ofs_lo_q (ofs_lo_q),
        .ofs_hi_q (ofs_hi_q)
    );

    function automatic logic [BW-1:0] exp_out();
        return oe_m ? dac_m : '0;
    endfunction

    task automatic randomize_codes();
        for (int c = 0; c < NCH; c++) begin
            code_a[c*CW +: CW] = CW'($urandom);
            code_b[c*CW +: CW] = CW'($urandom);
        end
    endtask

    // model one clock edge using the inputs currently driven
    task automatic model_edge();
        if (!load_n) begin
            for (int c = 0; c < NCH; c++) begin
                dac_m[c*CW +: CW] = sel_m[c] ? code_b[c*CW +: CW] : code_a[c*CW +: CW];
            end
        end
        if (wr_en) begin
            if (int'(wr_addr) < NG) sel_m[int'(wr_addr)*GS +: GS] = wr_data[GS-1:0];
            else if (wr_addr == 4'd8)  ctrl_m   = wr_data[2:0];
            else if (wr_addr == 4'd9)  ofs_lo_m = wr_data[13:0];
            else if (wr_addr == 4'd10) ofs_hi_m = wr_data[13:0];
            else if (wr_addr == 4'd11) sel_m    = {NCH{wr_data[0]}};
        end
        oe_m = clear_n;
    endtask

    task automatic check_all(input string tag);
        n_chk++;
        if (chan_out !== exp_out()) begin
            n_fail++;
            $display("FAIL %s chan_out act=%h exp=%h", tag, chan_out, exp_out());
        end
        n_chk++;
        if (out_en !== oe_m || ctrl_q !== ctrl_m || ofs_lo_q !== ofs_lo_m || ofs_hi_q !== ofs_hi_m) begin
            n_fail++;
            $display("FAIL %s regs act=%b/%h/%h/%h exp=%b/%h/%h/%h", tag,
                     out_en, ctrl_q, ofs_lo_q, ofs_hi_q, oe_m, ctrl_m, ofs_lo_m, ofs_hi_m);
        end
    endtask

    // drive one cycle, advance the model, sample a quarter period after the edge
    task automatic step(input logic we, input logic [3:0] a, input logic [15:0] d,
                        input logic ld_n, input logic clr_n, input string tag);
        wr_en = we; wr_addr = a; wr_data = d; load_n = ld_n; clear_n = clr_n;
        model_edge();
        @(posedge clk);
        #(PERIOD/4);
        check_all(tag);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        randomize_codes();
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        sel_m = '0; dac_m = '0; ctrl_m = '0; ofs_lo_m = 14'h1555; ofs_hi_m = 14'h1555; oe_m = 1'b0;
        check_all("R1 in reset");
        rst_n = 1'b1;
        step(1'b0, 4'd0, 16'h0, 1'b1, 1'b1, "R1 after reset");
        // R1: a load right after reset picks all A codes
        randomize_codes();
        step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1, "R1 default A select");

        // R2: per-channel select in group 2, then load
        step(1'b1, 4'd2, 16'h00A5, 1'b1, 1'b1, "R2 write group2");
        randomize_codes();
        step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1, "R2 mixed A/B load");
        step(1'b1, 4'd4, 16'hFF3C, 1'b1, 1'b1, "R2 write group4");
        randomize_codes();
        step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1, "R2 group4 load");

        // R4: write and load on the same edge uses the old select bits
        randomize_codes();
        step(1'b1, 4'd0, 16'h00FF, 1'b0, 1'b1, "R4 same-edge write");
        randomize_codes();
        step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1, "R4 new select applied");

        // R3: global set to B, global clear to A
        step(1'b1, 4'd11, 16'h0001, 1'b1, 1'b1, "R3 global B");
        randomize_codes();
        step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1, "R3 all B load");
        step(1'b1, 4'd11, 16'hFFFE, 1'b1, 1'b1, "R3 global A");
        randomize_codes();
        step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1, "R3 all A load");

        // R5: load high, codes change, outputs hold
        for (int k = 0; k < 4; k++) begin
            randomize_codes();
            step(1'b0, 4'd0, 16'h0, 1'b1, 1'b1, "R5 hold");
        end

        // R6, R7: control and offsets, upper data bits ignored
        step(1'b1, 4'd8, 16'hFFFD, 1'b1, 1'b1, "R6 ctrl write");
        step(1'b1, 4'd9, 16'hC000, 1'b1, 1'b1, "R7 ofs_lo write");
        step(1'b1, 4'd10, 16'hFFFF, 1'b1, 1'b1, "R7 ofs_hi write");

        // R9: unused addresses change nothing
        for (int a = 5; a < 8; a++) step(1'b1, 4'(a), 16'hFFFF, 1'b1, 1'b1, "R9 unused addr");
        for (int a = 12; a < 16; a++) step(1'b1, 4'(a), 16'hFFFF, 1'b1, 1'b1, "R9 unused addr");
        randomize_codes();
        step(1'b0, 4'd0, 16'h0, 1'b0, 1'b1, "R9 select intact");

        // R8: clear gates outputs, loads continue underneath
        step(1'b1, 4'd1, 16'h005A, 1'b1, 1'b0, "R8 clear low");
        randomize_codes();
        step(1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R8 load while cleared");
        step(1'b0, 4'd0, 16'h0, 1'b1, 1'b1, "R8 reopen shows load");

        // random mix
        for (int n = 0; n < 600; n++) begin
            randomize_codes();
            step(($urandom % 2) == 0, 4'($urandom), 16'($urandom),
                 ($urandom % 3) != 0, ($urandom % 8) != 0, "R4 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule